// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor that completes one instruction on every clock edge. The PC addresses an internal read-only instruction store. The fetched word is decoded by a fixed control table, two registers are read at once from a 32-entry register file, and a single ALU produces either the arithmetic result, the data-memory address or the branch comparison. The result is written back to the register file or to an internal data store at the next rising edge. The core supports nine operations: word load and store; add, subtract, AND, OR and signed set-less-than; branch-if-equal; and an absolute jump.

While reset is held, the two internal stores are filled through a word-wide load port: `ld_sel` 0 selects the instruction store and 1 selects the data store, and `ld_addr` is a word index. Once reset is released, execution starts at byte address 0. The `rf_*`, `dm_*` and `pc_o` outputs show, for the instruction in flight, the commit that will happen at the next rising edge. An environment can therefore follow the execution without a path into the core.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and neither `rf_we_o` nor `dm_we_o` is asserted. The register file resets to all zeros.
- R2: Unless a taken branch or a jump redirects it, the PC advances by 4 at each rising edge. Instructions are fetched from word index PC[..:2].
- R3: For an R-type instruction (opcode 0, funct 32 add, 34 sub, 36 and, 37 or), the result of rs (bits 25:21) op rt (bits 20:16) is written to rd (bits 15:11). Both source reads happen in the same cycle, and the value written by one instruction is visible to the next.
- R4: Set-less-than (opcode 0, funct 42) writes 1 to rd when rs is less than rt as signed numbers, and 0 otherwise.
- R5: A load (opcode 35) reads the data word at rs + sign-extended bits 15:0 and writes it to rt (bits 20:16). For example, a base of 1000 and an offset of 32 read byte address 1032.
- R6: A store (opcode 43) writes rt to the data word at rs + sign-extended offset and writes no register.
- R7: A branch (opcode 4) with rs equal to rt sets the PC to PC+4 + (sign-extended offset << 2). With rs not equal to rt it advances by 4. It writes neither store nor register.
- R8: A jump (opcode 2) sets the PC to {PC[31:28], bits 25:0, 2'b00} and writes nothing.
- R9: Register 0 always reads as zero. A write addressed to it is dropped and does not assert `rf_we_o`.
- R10: Negative 16-bit offsets are sign-extended for both memory addresses and backward branches.
- R11: An opcode outside the set above writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Preload strobe, written at the rising edge |
| ld_sel | input | 1 | Preload target: 0 instruction store, 1 data store |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Byte address of the instruction in flight |
| rf_we_o | output | 1 | Register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 32 | Value to be written |
| dm_we_o | output | 1 | Data-store write commits at the next edge |
| dm_addr_o | output | 32 | Byte address of the data access |
| dm_wdata_o | output | 32 | Word to be stored |

## Verification
The bench runs one program through a scoreboard that compares each cycle's commit against a hand-worked expectation. The program goes after the sign of set-less-than with mixed-sign operands, where an unsigned compare would write 0 instead of 1. It checks a write aimed at register 0, which a core without the guard would commit and then read back as non-zero. It uses negative offsets on a store and on a load: a zero-extending core would touch an address 64 KiB too high and lose the round trip. It also covers a taken branch, an untaken branch, a backward branch onto itself, a jump and an undefined opcode. A core that miscomputes any of these targets would drift into the skipped words, which hold register writes the scoreboard never expects.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_JUMP  = 6'd2;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    typedef struct packed {
        logic       dst_rd;     // 1: bits 15:11, 0: bits 20:16
        logic       opb_imm;    // 1: immediate as second operand
        logic       wb_mem;     // write back from data store
        logic       rf_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       is_br;
        logic       is_jmp;
        logic [1:0] alu_cls;    // 00 add, 01 sub, 10 by funct, 11 jump
    } ctrl_t;

    typedef struct packed {
        logic [31:0] pc;
    } core_st_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output alu_fn_e    alu_fn
);
    always_comb begin
        ctl = '0;
        case (opcode)
            OP_RTYPE: begin
                ctl.dst_rd  = 1'b1;
                ctl.rf_wr   = 1'b1;
                ctl.alu_cls = 2'b10;
            end
            OP_LOAD: begin
                ctl.opb_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.rf_wr   = 1'b1;
                ctl.mem_rd  = 1'b1;
            end
            OP_STORE: begin
                ctl.opb_imm = 1'b1;
                ctl.mem_wr  = 1'b1;
            end
            OP_BEQ: begin
                ctl.is_br   = 1'b1;
                ctl.alu_cls = 2'b01;
            end
            OP_JUMP: begin
                ctl.is_jmp  = 1'b1;
                ctl.alu_cls = 2'b11;
            end
            default: ctl = '0;
        endcase
    end

    always_comb begin
        case (ctl.alu_cls)
            2'b01:   alu_fn = ALU_SUB;
            2'b10: begin
                case (funct)
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: alu_fn = ALU_ADD;
                endcase
            end
            default: alu_fn = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int unsigned NREG = 32,
    parameter int unsigned W    = 32,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] rf_d [NREG];
    logic [W-1:0] rf_q [NREG];

    always_comb begin
        rf_d = rf_q;
        if (we && (wa != '0)) rf_d[wa] = wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : rf_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : rf_q[ra_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int unsigned IMEM_WORDS = 64,
    parameter int unsigned DMEM_WORDS = 512,
    parameter int unsigned LD_AW = $clog2((IMEM_WORDS > DMEM_WORDS) ? IMEM_WORDS : DMEM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             ld_sel,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [31:0]      ld_data,
    output logic [31:0]      pc_o,
    output logic             rf_we_o,
    output logic [4:0]       rf_waddr_o,
    output logic [31:0]      rf_wdata_o,
    output logic             dm_we_o,
    output logic [31:0]      dm_addr_o,
    output logic [31:0]      dm_wdata_o
);
    localparam int unsigned IAW = $clog2(IMEM_WORDS);
    localparam int unsigned DAW = $clog2(DMEM_WORDS);

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    core_st_t st_d, st_q;

    logic [31:0] instr;
    ctrl_t       ctl;
    alu_fn_e     alu_fn;
    logic [31:0] rs_val, rt_val, imm_sx, opb, alu_y, dm_rdata, wb_val;
    logic [31:0] pc_plus4, br_tgt, jmp_tgt;
    logic [4:0]  dst;
    logic        alu_zero, is_branch, is_jump, rf_commit;

    assign instr = imem[st_q.pc[IAW+1:2]];

    sc_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl),
        .alu_fn (alu_fn)
    );

    assign is_branch = ctl.is_br;
    assign is_jump   = ctl.is_jmp;
    assign dst       = ctl.dst_rd ? instr[15:11] : instr[20:16];
    assign imm_sx    = {{16{instr[15]}}, instr[15:0]};
    assign opb       = ctl.opb_imm ? imm_sx : rt_val;
    assign rf_commit = rst_n && ctl.rf_wr;

    sc_regfile #(.NREG(32), .W(32)) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .ra_a (instr[25:21]),
        .ra_b (instr[20:16]),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (rf_commit),
        .wa   (dst),
        .wd   (wb_val)
    );

    sc_alu #(.W(32)) u_alu (
        .a    (rs_val),
        .b    (opb),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign dm_rdata = dmem[alu_y[DAW+1:2]];
    assign wb_val   = ctl.wb_mem ? dm_rdata : alu_y;

    assign pc_plus4 = st_q.pc + 32'd4;
    assign br_tgt   = pc_plus4 + {imm_sx[29:0], 2'b00};
    assign jmp_tgt  = {st_q.pc[31:28], instr[25:0], 2'b00};

    always_comb begin
        st_d = st_q;
        if (is_jump)                     st_d.pc = jmp_tgt;
        else if (is_branch && alu_zero)  st_d.pc = br_tgt;
        else                             st_d.pc = pc_plus4;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (ld_en && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_sel)      dmem[ld_addr[DAW-1:0]] <= ld_data;
        else if (dm_we_o)         dmem[alu_y[DAW+1:2]]   <= rt_val;
    end

    assign pc_o       = st_q.pc;
    assign rf_we_o    = rf_commit && (dst != 5'd0);
    assign rf_waddr_o = dst;
    assign rf_wdata_o = wb_val;
    assign dm_we_o    = rst_n && ctl.mem_wr;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        is_branch,
    input logic        is_jump,
    input logic        alu_zero,
    input logic        rf_we,
    input logic        dm_we,
    input logic [4:0]  ra_a,
    input logic [31:0] rs_val
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (!rf_we && !dm_we && pc == 32'd0)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_branch && !is_jump) |=> (pc == $past(pc) + 32'd4)); // R2

    AST_NO_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && dm_we)); // R6

    AST_BEQ_UNTAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (is_branch && !alu_zero) |=> (pc == $past(pc) + 32'd4)); // R7

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        is_jump |=> (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00})); // R8

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_a == 5'd0) |-> (rs_val == 32'd0)); // R9
endmodule

bind sc_core sc_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc        (pc_o),
    .instr     (instr),
    .is_branch (is_branch),
    .is_jump   (is_jump),
    .alu_zero  (alu_zero),
    .rf_we     (rf_we_o),
    .dm_we     (dm_we_o),
    .ra_a      (instr[25:21]),
    .rs_val    (rs_val)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
    localparam int LD_AW = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_en = 1'b0;
    logic             ld_sel = 1'b0;
    logic [LD_AW-1:0] ld_addr = '0;
    logic [31:0]      ld_data = '0;
    logic [31:0]      pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]       rf_waddr_o;
    logic             rf_we_o, dm_we_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sc_core u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    typedef struct {
        logic [31:0] pc;
        logic        rwe;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        dwe;
        logic [31:0] da;
        logic [31:0] dd;
        string       tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic load_word(input logic sel, input int addr, input logic [31:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = LD_AW'(addr); ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic push_reg(input int pc, input int wa, input logic [31:0] wd, input string tag);
        exp_t e;
        e.pc = 32'(pc); e.rwe = 1'b1; e.wa = 5'(wa); e.wd = wd;
        e.dwe = 1'b0; e.da = '0; e.dd = '0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic push_none(input int pc, input string tag);
        exp_t e;
        e.pc = 32'(pc); e.rwe = 1'b0; e.wa = '0; e.wd = '0;
        e.dwe = 1'b0; e.da = '0; e.dd = '0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic push_store(input int pc, input logic [31:0] da, input logic [31:0] dd, input string tag);
        exp_t e;
        e.pc = 32'(pc); e.rwe = 1'b0; e.wa = '0; e.wd = '0;
        e.dwe = 1'b1; e.da = da; e.dd = dd; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares one scoreboard item per instruction cycle
    initial begin
        exp_t e;
        bit bad;
        wait (rst_n === 1'b1);
        while (sb.size() > 0) begin
            #2;
            e = sb.pop_front();
            checks++;
            bad = (pc_o !== e.pc) || (rf_we_o !== e.rwe) || (dm_we_o !== e.dwe);
            if (e.rwe && ((rf_waddr_o !== e.wa) || (rf_wdata_o !== e.wd))) bad = 1'b1;
            if (e.dwe && ((dm_addr_o !== e.da) || (dm_wdata_o !== e.dd))) bad = 1'b1;
            if (bad) begin
                errors++;
                $display("FAIL %s: got pc=%0d rwe=%0b wa=%0d wd=%h dwe=%0b da=%0d dd=%h, expected pc=%0d rwe=%0b wa=%0d wd=%h dwe=%0b da=%0d dd=%h",
                         e.tag, pc_o, rf_we_o, rf_waddr_o, rf_wdata_o, dm_we_o, dm_addr_o, dm_wdata_o,
                         e.pc, e.rwe, e.wa, e.wd, e.dwe, e.da, e.dd);
            end
            @(negedge clk);
        end
        done = 1'b1;
    end

    initial begin
        // data preload
        load_word(1'b1, 0, 32'd1000);
        load_word(1'b1, 2, 32'd7);
        load_word(1'b1, 3, 32'hFFFF_FFFB);
        load_word(1'b1, 258, 32'h1122_3344);
        // program
        load_word(1'b0, 0,  enc_i(6'd35, 0, 18, 0));
        load_word(1'b0, 1,  enc_i(6'd35, 18, 8, 32));
        load_word(1'b0, 2,  enc_i(6'd35, 0, 9, 8));
        load_word(1'b0, 3,  enc_i(6'd35, 0, 10, 12));
        load_word(1'b0, 4,  enc_r(9, 10, 11, 6'd32));
        load_word(1'b0, 5,  enc_r(9, 10, 12, 6'd34));
        load_word(1'b0, 6,  enc_r(8, 9, 13, 6'd36));
        load_word(1'b0, 7,  enc_r(8, 9, 14, 6'd37));
        load_word(1'b0, 8,  enc_r(10, 9, 15, 6'd42));
        load_word(1'b0, 9,  enc_r(9, 10, 16, 6'd42));
        load_word(1'b0, 10, enc_r(9, 9, 0, 6'd32));
        load_word(1'b0, 11, enc_r(0, 9, 17, 6'd32));
        load_word(1'b0, 12, enc_i(6'd43, 18, 8, -4));
        load_word(1'b0, 13, enc_i(6'd35, 18, 19, -4));
        load_word(1'b0, 14, enc_i(6'd4, 9, 10, 5));
        load_word(1'b0, 15, enc_i(6'd4, 19, 8, 2));
        load_word(1'b0, 16, enc_r(9, 9, 20, 6'd32));
        load_word(1'b0, 17, enc_r(9, 9, 20, 6'd32));
        load_word(1'b0, 18, 32'hFC00_0000);
        load_word(1'b0, 19, {6'd2, 26'd22});
        load_word(1'b0, 20, enc_r(9, 9, 21, 6'd32));
        load_word(1'b0, 21, enc_r(9, 9, 21, 6'd32));
        load_word(1'b0, 22, enc_r(17, 11, 22, 6'd32));
        load_word(1'b0, 23, enc_i(6'd4, 0, 0, -1));

        // R1: reset state
        #2;
        checks++;
        if (pc_o !== 32'd0 || rf_we_o !== 1'b0 || dm_we_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: got pc=%0d rwe=%0b dwe=%0b, expected 0 0 0", pc_o, rf_we_o, dm_we_o);
        end

        push_reg(0,  18, 32'd1000,       "R5 load base");
        push_reg(4,  8,  32'h1122_3344,  "R5 load 1000+32");
        push_reg(8,  9,  32'd7,          "R2 load");
        push_reg(12, 10, 32'hFFFF_FFFB,  "R2 load");
        push_reg(16, 11, 32'd2,          "R3 add");
        push_reg(20, 12, 32'd12,         "R3 sub");
        push_reg(24, 13, 32'd4,          "R3 and");
        push_reg(28, 14, 32'h1122_3347,  "R3 or");
        push_reg(32, 15, 32'd1,          "R4 slt true");
        push_reg(36, 16, 32'd0,          "R4 slt false");
        push_none(40,                    "R9 write to r0");
        push_reg(44, 17, 32'd7,          "R9 r0 reads zero");
        push_store(48, 32'd996, 32'h1122_3344, "R6 store");
        push_reg(52, 19, 32'h1122_3344,  "R10 negative offset");
        push_none(56,                    "R7 untaken");
        push_none(60,                    "R7 taken");
        push_none(72,                    "R11 unknown opcode");
        push_none(76,                    "R8 jump");
        push_reg(88, 22, 32'd9,          "R8 jump target");
        push_none(92,                    "R10 backward branch");
        push_none(92,                    "R7 self loop");
        push_none(92,                    "R7 self loop");

        @(negedge clk);
        rst_n = 1'b1;
    end

    // watchdog
    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule